// File: doc/BRIEF.md
# Approximate Unsigned Array Multiplier

This block multiplies two unsigned N-bit operands and returns a 2N-bit product, trading exactness in the low-order part of the result for simpler reduction logic. Every operand bit pair is ANDed into a partial-product matrix, where the bit pair (i, j) carries weight 2^(i+j). The matrix is then collapsed to the final product by exact counting and a carry-propagate sum. In the lowest APPROX_COLS columns, the first reduction step replaces exact counters with AND-OR compressors. Each of these compressors emits bits of the same weight as its inputs, so a compressed column only gets shorter and never sends carries to its neighbour.

Each approximated column of height h is covered greedily. Four-input compressors are used first. The remainder is handled by a three- or two-input compressor, or by a five-input one when the column would otherwise leave a single bit after a group of four. The column always leaves with ceil(h/2) bits. The compressors drop only AND terms of three or more inputs, so they can lose value but never add it. Setting APPROX_COLS to zero gives an exact multiplier. An optional output register adds one cycle of latency and a valid strobe.

Top module: `approx_mult`

## Requirements
- R1: With APPROX_COLS = 0 the product equals a*b for every operand pair.
- R2: The product never exceeds the exact value a*b.
- R3: The shortfall a*b - product is always below N * 2^APPROX_COLS.
- R4: When either operand is zero the product is zero, and when either operand has exactly one bit set the product is exact.
- R5: An approximated column of height h is cut to ceil(h/2) same-weight bits, using the compressors below. Any leftover ones go to a two-input compressor (p0|p1) or a three-input one ({p0p1|p2, p0|p1}). The four-input form is {p0p1|p2|p3, p2p3|p0|p1}. The five-input form is {p0p1|p2|p3, p0|p1, p2p3|p4}. Inside a column, bits are ordered by ascending index of operand a. For N=8 and APPROX_COLS=8 this gives 0xFF*0xFF = 64171, 3*3 = 7 and 0x0F*0x0F = 203.
- R6: Columns at or above APPROX_COLS are summed exactly. With every column approximated (APPROX_COLS=15, N=8), 0xFF*0xFF = 43435.
- R7: With REG_OUT=1, a product captured with in_valid high appears one clock later, with out_valid high.
- R8: With REG_OUT=1, a cycle with in_valid low leaves the product unchanged and gives out_valid low on the next cycle.
- R9: With REG_OUT=1, rst_n low at a clock edge (a synchronous reset) clears out_valid and product to zero.
- R10: With REG_OUT=0, out_valid follows in_valid and product follows the operands combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier |
| out_valid | output | 1 | Product is valid |
| product | output | 2N | Approximate product |

## Verification
The block is first driven with hand-picked operand pairs whose expected results were derived column by column from the compressor equations. All-ones operands make every compressor saturate, so they expose the full loss in each column; they also separate a low-column setting from an all-column setting. Small dense operands such as 3 and 0x0F give columns where the greedy grouping and the bit order decide the result. One-hot and zero operands show that columns with a single set bit lose nothing. An exhaustive sweep of all operand pairs then checks the exact build bit for bit, and the approximate builds against the underestimate property and the error bound. Reset, hold and pass-through behaviour are checked with short directed sequences.

// File: rtl/approx_mult.sv
module approx_mult #(
  parameter int N           = 8,
  parameter int APPROX_COLS = 8,
  parameter bit REG_OUT     = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic           out_valid,
  output logic [2*N-1:0] product
);
  localparam int W  = 2 * N;
  localparam int NC = W - 1;
  localparam int CW = $clog2(N + 1);

  function automatic int col_h(input int k);
    return (k < N) ? k + 1 : W - 1 - k;
  endfunction

  function automatic logic [3:0] squeeze4(input logic p0, p1, p2, p3);
    return {2'b00, (p0 & p1) | p2 | p3, (p2 & p3) | p0 | p1};
  endfunction

  function automatic logic [3:0] squeeze5(input logic p0, p1, p2, p3, p4);
    return {1'b0, (p0 & p1) | p2 | p3, p0 | p1, (p2 & p3) | p4};
  endfunction

  function automatic logic [CW-1:0] squeeze_col(input logic [N-1:0] v, input int h);
    logic [CW-1:0] s;
    int t;
    s = '0;
    t = 0;
    for (int g = 0; g < N; g++) begin
      if ((h - t) == 4 || (h - t) >= 6) begin
        s = s + CW'($countones(squeeze4(v[t], v[t+1], v[t+2], v[t+3])));
        t = t + 4;
      end
    end
    case (h - t)
      1: s = s + CW'(v[t]);
      2: s = s + CW'(v[t] | v[t+1]);
      3: s = s + CW'((v[t] & v[t+1]) | v[t+2]) + CW'(v[t] | v[t+1]);
      5: s = s + CW'($countones(squeeze5(v[t], v[t+1], v[t+2], v[t+3], v[t+4])));
      default: ;
    endcase
    return s;
  endfunction

  logic [N-1:0] cols [NC];
  logic [W-1:0] comb_p;

  always_comb begin
    for (int k = 0; k < NC; k++) cols[k] = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        cols[i+j][(i + j < N) ? i : N - 1 - j] = a[i] & b[j];
  end

  always_comb begin
    comb_p = '0;
    for (int k = 0; k < NC; k++) begin
      if (k < APPROX_COLS)
        comb_p = comb_p + (W'(squeeze_col(cols[k], col_h(k))) << k);
      else
        comb_p = comb_p + (W'($countones(cols[k])) << k);
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          product   <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) product <= comb_p;
        end
      end

      a_r7_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(product)));
      a_r9_sync_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && product == '0));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign product   = comb_p;
    end
  endgenerate

  logic [W-1:0] exact_p;
  assign exact_p = W'(a) * W'(b);

  a_r2_underestimate: assert property (@(posedge clk) disable iff (!rst_n)
    comb_p <= exact_p);
  a_r3_error_bound: assert property (@(posedge clk) disable iff (!rst_n)
    64'(exact_p - comb_p) < (64'(N) << APPROX_COLS));
  a_r4_sparse_exact: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(a) <= 1 || $countones(b) <= 1) |-> comb_p == exact_p);

  generate
    if (APPROX_COLS == 0) begin : g_exact_chk
      a_r1_exact_mode: assert property (@(posedge clk) disable iff (!rst_n)
        comb_p == exact_p);
    end
  endgenerate
endmodule

// File: tb/approx_mult_bench.sv
module approx_mult_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic v_d, v_x, v_c;
  logic [15:0] p_d, p_x, p_c;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  approx_mult #(.N(8), .APPROX_COLS(8), .REG_OUT(1'b1)) u_approx_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(v_d), .product(p_d));
  approx_mult #(.N(8), .APPROX_COLS(0), .REG_OUT(1'b1)) u_approx_mult_ex (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(v_x), .product(p_x));
  approx_mult #(.N(8), .APPROX_COLS(15), .REG_OUT(1'b0)) u_approx_mult_all (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(v_c), .product(p_c));

  // {a, b, expected with 8 low columns, expected with all columns}
  localparam logic [47:0] VEC [8] = '{
    {8'h00, 8'h00, 16'd0,     16'd0},
    {8'hFF, 8'hFF, 16'd64171, 16'd43435},
    {8'h03, 8'h03, 16'd7,     16'd7},
    {8'h0F, 8'h0F, 16'd203,   16'd203},
    {8'h01, 8'hB7, 16'd183,   16'd183},
    {8'h80, 8'hFF, 16'd32640, 16'd32640},
    {8'h02, 8'h02, 16'd4,     16'd4},
    {8'hFF, 8'h00, 16'd0,     16'd0}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ok(input string req, input bit ok, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    real rel_d, rel_c;
    longint ex;
    logic [7:0] pa, pb;
    rel_d = 0.0;
    rel_c = 0.0;

    repeat (3) @(negedge clk);
    chk("R9 reset valid", v_d, 0);
    chk("R9 reset product", p_d, 0);
    rst_n = 1'b1;

    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      in_valid = 1'b1;
      a = VEC[n][47:40];
      b = VEC[n][39:32];
      #1;
      chk("R6 R10 all-column product", p_c, VEC[n][15:0]);
      chk("R10 pass-through valid", v_c, 1);
      @(negedge clk);
      chk("R5 R7 low-column product", p_d, VEC[n][31:16]);
      chk("R7 valid strobe", v_d, 1);
      chk("R1 exact product", p_x, longint'(VEC[n][47:40]) * longint'(VEC[n][39:32]));
    end

    // R8: idle cycle holds the last product
    @(negedge clk);
    in_valid = 1'b0;
    a = 8'h55;
    b = 8'hAA;
    #1;
    chk("R10 pass-through idle valid", v_c, 0);
    @(negedge clk);
    chk("R8 idle valid low", v_d, 0);
    chk("R8 idle product held", p_d, 0);
    in_valid = 1'b1;
    a = 8'hFF;
    b = 8'hFF;
    @(negedge clk);
    in_valid = 1'b0;
    a = 8'h01;
    b = 8'h01;
    @(negedge clk);
    chk("R8 product held after idle", p_d, 64171);
    chk("R8 valid low after idle", v_d, 0);

    // exhaustive sweep; registered outputs are checked one cycle behind
    in_valid = 1'b1;
    pa = '0;
    pb = '0;
    for (int idx = 0; idx <= 65536; idx++) begin
      @(negedge clk);
      if (idx > 0) begin
        ex = longint'(pa) * longint'(pb);
        if (p_x != ex) chk("R1 sweep exact", p_x, ex);
        if (!(p_d <= ex)) chk_ok("R2 sweep underestimate", 0, p_d, ex);
        if (!((ex - p_d) < 2048)) chk_ok("R3 sweep bound", 0, ex - p_d, 2048);
        if (pa == 0 || pb == 0) begin
          if (p_d != 0) chk("R4 zero operand", p_d, 0);
        end
        if ($countones(pa) == 1 || $countones(pb) == 1) begin
          if (p_d != ex) chk("R4 one-hot operand", p_d, ex);
        end
        if (ex > 0) rel_d += real'(ex - longint'(p_d)) / real'(ex);
      end
      if (idx < 65536) begin
        a = idx[15:8];
        b = idx[7:0];
        pa = a;
        pb = b;
        #1;
        ex = longint'(a) * longint'(b);
        if (!(p_c <= ex)) chk_ok("R2 sweep all-column underestimate", 0, p_c, ex);
        if (ex > 0) rel_c += real'(ex - longint'(p_c)) / real'(ex);
      end
    end
    chk_ok("R2 R3 sweep completed", 1, 0, 0);
    $display("mean relative error: cols=0 0.000000 cols=8 %f cols=15 %f",
             rel_d / 65025.0, rel_c / 65025.0);

    // R9: synchronous reset while valid operands are present
    @(negedge clk);
    in_valid = 1'b1;
    a = 8'hFF;
    b = 8'hFF;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 mid-run reset valid", v_d, 0);
    chk("R9 mid-run reset product", p_d, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 first product after reset", p_d, 64171);

    finish_run();
  end
endmodule